// File: doc/BRIEF.md
# PLL Enable and Stop-Mode Power Control

This block keeps the two control bits that decide where the core clock comes from and which analog parts stay powered while the chip is in its STOP state. The enable bit picks the clock source: the PLL VCO output or the raw external clock. Software can turn this bit on, but it cannot turn it off. The only way to clear it is the level of a strap pin, which the block samples while hardware reset is held. The stop-power bit is fully writable and is cleared by reset.

During STOP, the two bits together decide whether the PLL and the crystal oscillator keep running. This trades wake-up time against standby power. The VCO, the oscillator and the clock multiplexer are not modelled. They appear only as enable and select outputs. The lock output is forced high whenever the PLL is not in use.

Software writes both bits through a simple strobe-and-data port and reads them back on a read bus.

Top module: `pll_pwr_ctl`

## Requirements
- R1: `clk_sel_vco` equals the enable bit. A value of 1 selects the VCO output and 0 selects the external clock.
- R2: While the enable bit is 0, `pll_en` is 0 whatever the other inputs are.
- R3: While the enable bit is 0, `lock_o` is 1. While the enable bit is 1, `lock_o` follows `pll_lock_i`.
- R4: A write with data bit 0 set makes the enable bit 1 on the clock edge that samples the strobe. A write with data bit 0 clear leaves the enable bit unchanged.
- R5: While `rst_n` is low, each clock edge loads the enable bit from `strap_i` and clears the stop-power bit.
- R6: With `stop_i` high, both `pll_en` and `osc_en` are 0 if the stop-power bit is 0. If the stop-power bit is 1, `osc_en` is 1 and `pll_en` equals the enable bit.
- R7: With `stop_i` low, `osc_en` is 1 and `pll_en` equals the enable bit.
- R8: `fast_rec_o` is 1 exactly when the stop-power bit is 1.
- R9: `rd_data` carries the enable bit at position 0 and the stop-power bit at position 1, with all other bits 0. A write shows on `rd_data` only after the edge that samples the strobe.
- R10: A write loads the stop-power bit from data bit 1. Both 0 and 1 take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, synchronous |
| strap_i | input | 1 | Reset-time strap; sets the enable bit while in reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data; bit 0 is enable, bit 1 is stop-power |
| stop_i | input | 1 | Chip is in the STOP state |
| pll_lock_i | input | 1 | Raw lock indication from the PLL |
| rd_data | output | DATA_W | Read-back of the control bits |
| pll_en | output | 1 | PLL/VCO enable |
| osc_en | output | 1 | Crystal oscillator enable |
| clk_sel_vco | output | 1 | Clock source select, 1 = VCO |
| lock_o | output | 1 | Lock status, forced high when the PLL is unused |
| fast_rec_o | output | 1 | Recovery class, 1 = fast |

## Verification
A register write and a change of the STOP indication can land in the same cycle. In that cycle the enables must still follow the old register values, and they must switch only after the edge. The bench provokes this by raising `stop_i` together with a write that sets the stop-power bit. It checks `osc_en` low before the edge and high after it. It also runs the reverse case, where a write clears the bit during STOP. Every reachable pair of register states, for both strap levels, is swept against all combinations of STOP and raw lock, with the expected outputs worked out from the decode table.

// File: rtl/pll_pwr_pkg.sv
package pll_pwr_pkg;
  localparam int PEN_POS  = 0;
  localparam int PSTP_POS = 1;

  typedef enum logic { REC_SLOW = 1'b0, REC_FAST = 1'b1 } rec_class_e;

  // Enable bit is sticky: software can only add to it.
  function automatic logic pen_next(input logic cur, input logic wbit);
    return cur | wbit;
  endfunction

  // Oscillator stays up when running, or in STOP with stop-power set.
  function automatic logic osc_keep(input logic stop, input logic pstp);
    return (!stop) | pstp;
  endfunction

  function automatic logic pll_run(input logic stop, input logic pstp, input logic pen);
    return pen & osc_keep(stop, pstp);
  endfunction

  function automatic rec_class_e rec_class(input logic pstp);
    return pstp ? REC_FAST : REC_SLOW;
  endfunction
endpackage

// File: rtl/pll_ctl_reg.sv
module pll_ctl_reg
  import pll_pwr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_i,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pen_o,
  output logic              pstp_o
);
  logic pen_q, pstp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pen_q  <= strap_i;
      pstp_q <= 1'b0;
    end else if (wr_en) begin
      pen_q  <= pen_next(pen_q, wr_data[PEN_POS]);
      pstp_q <= wr_data[PSTP_POS];
    end
  end

  assign pen_o  = pen_q;
  assign pstp_o = pstp_q;
endmodule

// File: rtl/pll_stop_decode.sv
module pll_stop_decode
  import pll_pwr_pkg::*;
(
  input  logic stop_i,
  input  logic pen_i,
  input  logic pstp_i,
  output logic pll_en_o,
  output logic osc_en_o,
  output logic fast_o
);
  rec_class_e rc;

  always_comb begin
    osc_en_o = osc_keep(stop_i, pstp_i);
    pll_en_o = pll_run(stop_i, pstp_i, pen_i);
    rc       = rec_class(pstp_i);
    fast_o   = (rc == REC_FAST);
  end
endmodule

// File: rtl/pll_lock_mux.sv
module pll_lock_mux (
  input  logic pen_i,
  input  logic raw_lock_i,
  output logic sel_vco_o,
  output logic lock_o
);
  always_comb begin
    sel_vco_o = pen_i;
    lock_o    = pen_i ? raw_lock_i : 1'b1;
  end
endmodule

// File: rtl/pll_pwr_ctl.sv
module pll_pwr_ctl
  import pll_pwr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_i,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stop_i,
  input  logic              pll_lock_i,
  output logic [DATA_W-1:0] rd_data,
  output logic              pll_en,
  output logic              osc_en,
  output logic              clk_sel_vco,
  output logic              lock_o,
  output logic              fast_rec_o
);
  localparam int UNUSED_W = DATA_W - 2;

  // Named internal events for the checker.
  logic pen_w, pstp_w;
  logic pen_set_req;

  pll_ctl_reg #(.DATA_W(DATA_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .strap_i (strap_i),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .pen_o   (pen_w),
    .pstp_o  (pstp_w)
  );

  pll_stop_decode u_dec (
    .stop_i   (stop_i),
    .pen_i    (pen_w),
    .pstp_i   (pstp_w),
    .pll_en_o (pll_en),
    .osc_en_o (osc_en),
    .fast_o   (fast_rec_o)
  );

  pll_lock_mux u_lock (
    .pen_i      (pen_w),
    .raw_lock_i (pll_lock_i),
    .sel_vco_o  (clk_sel_vco),
    .lock_o     (lock_o)
  );

  assign pen_set_req = wr_en & wr_data[PEN_POS];

  generate
    if (UNUSED_W > 0) begin : g_pad
      assign rd_data = {{UNUSED_W{1'b0}}, pstp_w, pen_w};
    end else begin : g_nopad
      assign rd_data = {pstp_w, pen_w};
    end
  endgenerate
endmodule

// File: rtl/pll_pwr_ctl_chk.sv
module pll_pwr_ctl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_i,
  input logic              pll_lock_i,
  input logic              pen_set_req,
  input logic [DATA_W-1:0] rd_data,
  input logic              pll_en,
  input logic              osc_en,
  input logic              clk_sel_vco,
  input logic              lock_o,
  input logic              fast_rec_o
);
  AST_SEL_FOLLOWS_PEN: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel_vco == rd_data[0]); // R1
  AST_PLL_OFF_NO_PEN: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[0] |-> !pll_en); // R2
  AST_LOCK_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[0] |-> lock_o); // R3
  AST_LOCK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[0] |-> (lock_o == pll_lock_i)); // R3
  AST_PEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[0] |=> rd_data[0]); // R4
  AST_PEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pen_set_req |=> rd_data[0]); // R4
  AST_RESET_PSTP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rd_data[1]); // R5
  AST_STOP_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !rd_data[1]) |-> (!pll_en && !osc_en)); // R6
  AST_STOP_OSC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && rd_data[1]) |-> (osc_en && (pll_en == rd_data[0]))); // R6
  AST_RUN_OSC_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_i |-> (osc_en && (pll_en == rd_data[0]))); // R7
  AST_FAST_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    fast_rec_o == rd_data[1]); // R8
  AST_RD_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data >> 2) == '0); // R9
endmodule

bind pll_pwr_ctl pll_pwr_ctl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stop_i      (stop_i),
  .pll_lock_i  (pll_lock_i),
  .pen_set_req (pen_set_req),
  .rd_data     (rd_data),
  .pll_en      (pll_en),
  .osc_en      (osc_en),
  .clk_sel_vco (clk_sel_vco),
  .lock_o      (lock_o),
  .fast_rec_o  (fast_rec_o)
);

// File: tb/sim_pll_pwr_ctl.sv
module sim_pll_pwr_ctl;
  localparam int CLK_PER = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_i = 1'b0;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic stop_i = 1'b0;
  logic pll_lock_i = 1'b0;
  logic [DW-1:0] rd_data;
  logic pll_en, osc_en, clk_sel_vco, lock_o, fast_rec_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic pen_m, pstp_m;

  always #(CLK_PER/2) clk = ~clk;

  pll_pwr_ctl #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .wr_en(wr_en),
    .wr_data(wr_data), .stop_i(stop_i), .pll_lock_i(pll_lock_i),
    .rd_data(rd_data), .pll_en(pll_en), .osc_en(osc_en),
    .clk_sel_vco(clk_sel_vco), .lock_o(lock_o), .fast_rec_o(fast_rec_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rd_exp(input logic p, input logic s);
    logic [DW-1:0] v;
    v = '0;
    v[0] = p;
    v[1] = s;
    return v;
  endfunction

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; strap_i = strap; wr_en = 1'b0; stop_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    pen_m = strap; pstp_m = 1'b0;
    #1;
    chk("R5 pen from strap", {31'b0, rd_data[0]}, {31'b0, strap});
    chk("R5 pstp cleared", {31'b0, rd_data[1]}, 32'd0);
    chk("R9 read image", {24'b0, rd_data}, {24'b0, rd_exp(pen_m, pstp_m)});
  endtask

  task automatic sweep_out();
    for (int s = 0; s < 2; s++) begin
      for (int l = 0; l < 2; l++) begin
        logic eo, ep, el;
        @(negedge clk);
        stop_i = s[0]; pll_lock_i = l[0];
        #1;
        eo = (s == 0) ? 1'b1 : pstp_m;
        ep = eo ? pen_m : 1'b0;
        el = pen_m ? l[0] : 1'b1;
        chk(s == 0 ? "R7 osc_en" : "R6 osc_en", {31'b0, osc_en}, {31'b0, eo});
        chk(pen_m ? (s == 0 ? "R7 pll_en" : "R6 pll_en") : "R2 pll_en",
            {31'b0, pll_en}, {31'b0, ep});
        chk("R3 lock_o", {31'b0, lock_o}, {31'b0, el});
        chk("R1 clk_sel_vco", {31'b0, clk_sel_vco}, {31'b0, pen_m});
        chk("R8 fast_rec_o", {31'b0, fast_rec_o}, {31'b0, pstp_m});
      end
    end
    @(negedge clk);
    stop_i = 1'b0;
  endtask

  task automatic do_write(input logic [1:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = '0;
    wr_data[1:0] = w;
    wr_data[DW-1] = 1'b1;   // high bit must not reach the read image
    #1;
    chk("R9 write not yet visible", {24'b0, rd_data}, {24'b0, rd_exp(pen_m, pstp_m)});
    @(negedge clk);
    wr_en = 1'b0;
    pen_m = pen_m | w[0];
    pstp_m = w[1];
    #1;
    chk(w[0] ? "R4 pen set" : "R4 pen write 0 ignored", {31'b0, rd_data[0]}, {31'b0, pen_m});
    chk("R10 pstp loaded", {31'b0, rd_data[1]}, {31'b0, pstp_m});
    chk("R9 read image", {24'b0, rd_data}, {24'b0, rd_exp(pen_m, pstp_m)});
  endtask

  initial begin
    #(CLK_PER * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1:0] seq [7];
    seq = '{2'b00, 2'b10, 2'b01, 2'b00, 2'b11, 2'b10, 2'b00};
    // strap 1 first, then strap 0 proves reset clears a set enable bit
    for (int st = 1; st >= 0; st--) begin
      do_reset(st[0]);
      sweep_out();
      foreach (seq[i]) begin
        do_write(seq[i]);
        sweep_out();
      end
    end

    // Same-cycle write and STOP entry: old state holds until the edge.
    do_reset(1'b0);
    @(negedge clk);
    stop_i = 1'b1; wr_en = 1'b1; wr_data = '0; wr_data[1] = 1'b1;
    #1;
    chk("R6 osc off before edge", {31'b0, osc_en}, 32'd0);
    @(negedge clk);
    wr_en = 1'b0; pstp_m = 1'b1;
    #1;
    chk("R6 osc kept after edge", {31'b0, osc_en}, 32'd1);
    chk("R2 pll stays off", {31'b0, pll_en}, 32'd0);
    chk("R8 fast after edge", {31'b0, fast_rec_o}, 32'd1);
    // clear PSTP while in STOP
    @(negedge clk);
    wr_en = 1'b1; wr_data = '0;
    #1;
    chk("R6 osc still on before edge", {31'b0, osc_en}, 32'd1);
    @(negedge clk);
    wr_en = 1'b0; pstp_m = 1'b0;
    #1;
    chk("R10 pstp cleared in STOP", {31'b0, osc_en}, 32'd0);
    stop_i = 1'b0;
    #1;
    chk("R7 osc on after STOP", {31'b0, osc_en}, 32'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule